// File: doc/BRIEF.md
# Vectored Interrupt Controller with Fast Request Path

This block gathers a parameterised set of interrupt inputs and turns them into two requests for a processor: a normal request line fed by sources 1 and up, and a fast request line fed only by source 0. Each input passes through a synchronizer. The mode of each source picks its trigger from four choices: low level, high level, falling edge or rising edge. Edge-triggered sources latch a pending bit. Level-sensitive sources report their current level.

Software works the block over a small word-addressed register bus. Enables are changed only through two write-one command words, one that sets bits and one that clears them, and the resulting mask is read back from a separate read-only word. Two more write-one command words raise or drop pending bits on edge-configured sources, which lets any such source act as a software interrupt. Reading the normal vector word returns the handler address of the lowest-numbered enabled pending source and acknowledges it. If nothing qualifies, the read returns a programmable spurious value. Source 0 takes no part in priority selection. Its handler address comes back through its own fast vector word.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset every source is disabled (mask reads 0), every mode field reads 0 (low level), and both irq_o and fiq_o are low.
- R2: A write to the enable word (address 0x00) sets each mask bit whose data bit is 1 and leaves the other bits alone. The mask is read at address 0x02.
- R3: A write to the disable word (address 0x01) clears each mask bit whose data bit is 1 and leaves the other bits alone.
- R4: irq_o is high exactly when some enabled source numbered 1 or higher is pending. A disabled pending source neither raises irq_o nor blocks any enabled one.
- R5: When several enabled sources are pending, the lowest-numbered one is selected. Its vector (vector words at 0x20 plus the source number) is returned by a read of address 0x06. Read data appears on bus_rdata one clock after the read.
- R6: A read of 0x06 clears the pending bit of the selected source if that source is edge triggered. A level source stays pending while its level is active.
- R7: A read of 0x06 while no enabled source from 1 up is pending returns the spurious vector held at address 0x08.
- R8: A write to 0x03 sets, and a write to 0x04 clears, the pending bit of each edge-configured source whose data bit is 1. Both writes have no effect on level-configured sources.
- R9: The mode field (words at 0x10 plus the source number, bits 1:0) selects 0 for low level, 1 for high level, 2 for falling edge and 3 for rising edge. An edge pending bit stays set after the input goes quiet and holds until it is cleared.
- R10: Source 0 drives only fiq_o, which is high when source 0 is enabled and pending under any of the four modes. Source 0 never raises irq_o.
- R11: A read of 0x07 while fiq_o is high returns the vector of source 0 and clears its pending bit if source 0 is edge triggered. While fiq_o is low the read returns the spurious vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC | Asynchronous interrupt inputs; bit 0 is the fast source |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid the cycle after a read |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest state to reach from the ports is one where several edge sources are pending at once under a mixed mask, with disabled pending sources sitting below enabled ones. Only that state shows whether priority skips disabled bits and whether acknowledgment clears only the selected bit. The stimulus gets there without timing any input edges: it programs every source as an edge source, then uses the software set command with random patterns under random masks. It then reads the vector word twice in a row to follow the acknowledgment order. Directed sequences cover level sources, the falling-edge latch and each trigger mode of the fast source.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_RISE = 2'd3
    } trig_e;

    // Word addresses; per-source blocks hold up to 16 sources
    localparam int unsigned A_ENA   = 'h00;
    localparam int unsigned A_DIS   = 'h01;
    localparam int unsigned A_MASK  = 'h02;
    localparam int unsigned A_PSET  = 'h03;
    localparam int unsigned A_PCLR  = 'h04;
    localparam int unsigned A_NVEC  = 'h06;
    localparam int unsigned A_FVEC  = 'h07;
    localparam int unsigned A_SPUR  = 'h08;
    localparam int unsigned A_MODE0 = 'h10;
    localparam int unsigned A_VEC0  = 'h20;

endpackage

// File: rtl/ivc_sync.sv
module ivc_sync #(
    parameter int NSRC   = 8,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] async_i,
    output logic [NSRC-1:0] lvl_o,
    output logic [NSRC-1:0] prev_o
);

    for (genvar g = 0; g < NSRC; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
                prev_q  <= 1'b0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[g]};
                prev_q  <= chain_q[STAGES-1];
            end
        end

        assign lvl_o[g]  = chain_q[STAGES-1];
        assign prev_o[g] = prev_q;
    end

endmodule

// File: rtl/ivc_prio.sv
module ivc_prio #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IW'(i);
            end
        end
        any_o = |req_i;
    end

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import ivc_pkg::*;
#(
    parameter int NSRC        = 8,
    parameter int DW          = 32,
    parameter int AW          = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            bus_en,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            irq_o,
    output logic            fiq_o
);

    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    typedef struct packed {
        logic [NSRC-1:0]         en;
        logic [NSRC-1:0]         pend;
        logic [NSRC-1:0][1:0]    mode;
        logic [NSRC-1:0][DW-1:0] vec;
        logic [DW-1:0]           spur;
        logic [DW-1:0]           rdata;
    } st_t;

    st_t st_d, st_q;

    logic [NSRC-1:0] lvl, prv;
    logic [NSRC-1:0] hit, evt, is_edge;
    logic [NSRC-1:0] nrm_req;
    logic            nrm_any;
    logic [IW-1:0]   nrm_idx;
    logic            wr_acc, rd_acc;
    logic            ack_nrm, ack_fast;

    // Names brought out for the bound checker
    logic [NSRC-1:0] en_q;
    logic [DW-1:0]   spur_q;
    assign en_q   = st_q.en;
    assign spur_q = st_q.spur;

    ivc_sync #(.NSRC(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .lvl_o   (lvl),
        .prev_o  (prv)
    );

    // Source 0 is excluded from normal priority
    assign nrm_req = st_q.pend & st_q.en & ~NSRC'(1);

    ivc_prio #(.N(NSRC), .IW(IW)) u_prio (
        .req_i (nrm_req),
        .any_o (nrm_any),
        .idx_o (nrm_idx)
    );

    // Trigger decode per source
    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            is_edge[i] = st_q.mode[i][1];
            unique case (trig_e'(st_q.mode[i]))
                TRIG_LOW:  begin hit[i] = ~lvl[i]; evt[i] = 1'b0;            end
                TRIG_HIGH: begin hit[i] =  lvl[i]; evt[i] = 1'b0;            end
                TRIG_FALL: begin hit[i] = 1'b0;    evt[i] = ~lvl[i] & prv[i]; end
                default:   begin hit[i] = 1'b0;    evt[i] = lvl[i] & ~prv[i]; end
            endcase
        end
    end

    assign wr_acc   = bus_en & bus_wr;
    assign rd_acc   = bus_en & ~bus_wr;
    assign ack_nrm  = rd_acc & (bus_addr == AW'(A_NVEC)) & nrm_any;
    assign ack_fast = rd_acc & (bus_addr == AW'(A_FVEC)) & fiq_o;

    always_comb begin
        st_d = st_q;

        // Configuration writes
        if (wr_acc) begin
            if (bus_addr == AW'(A_ENA)) st_d.en = st_q.en | bus_wdata[NSRC-1:0];
            if (bus_addr == AW'(A_DIS)) st_d.en = st_q.en & ~bus_wdata[NSRC-1:0];
            if (bus_addr == AW'(A_SPUR)) st_d.spur = bus_wdata;
            for (int i = 0; i < NSRC; i++) begin
                if (bus_addr == AW'(A_MODE0 + i)) st_d.mode[i] = bus_wdata[1:0];
                if (bus_addr == AW'(A_VEC0 + i))  st_d.vec[i]  = bus_wdata;
            end
        end

        // Pending state
        for (int i = 0; i < NSRC; i++) begin
            if (is_edge[i]) begin
                if (wr_acc && bus_addr == AW'(A_PSET) && bus_wdata[i]) st_d.pend[i] = 1'b1;
                if (wr_acc && bus_addr == AW'(A_PCLR) && bus_wdata[i]) st_d.pend[i] = 1'b0;
                if (ack_nrm && nrm_idx == IW'(i)) st_d.pend[i] = 1'b0;
                if (ack_fast && i == 0) st_d.pend[i] = 1'b0;
                if (evt[i]) st_d.pend[i] = 1'b1;
            end else begin
                st_d.pend[i] = hit[i];
            end
        end

        // Read data, registered
        if (rd_acc) begin
            st_d.rdata = '0;
            if (bus_addr == AW'(A_MASK)) st_d.rdata[NSRC-1:0] = st_q.en;
            if (bus_addr == AW'(A_SPUR)) st_d.rdata = st_q.spur;
            if (bus_addr == AW'(A_NVEC)) st_d.rdata = nrm_any ? st_q.vec[nrm_idx] : st_q.spur;
            if (bus_addr == AW'(A_FVEC)) st_d.rdata = fiq_o ? st_q.vec[0] : st_q.spur;
            for (int i = 0; i < NSRC; i++) begin
                if (bus_addr == AW'(A_MODE0 + i)) st_d.rdata[1:0] = st_q.mode[i];
                if (bus_addr == AW'(A_VEC0 + i))  st_d.rdata = st_q.vec[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o     = nrm_any;
    assign fiq_o     = st_q.en[0] & st_q.pend[0];
    assign bus_rdata = st_q.rdata;

endmodule

// File: rtl/ivc_chk.sv
module ivc_chk
    import ivc_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int DW   = 32,
    parameter int AW   = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_en,
    input logic            bus_wr,
    input logic [AW-1:0]   bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic [DW-1:0]   bus_rdata,
    input logic            irq_o,
    input logic            fiq_o,
    input logic [NSRC-1:0] en_q,
    input logic [DW-1:0]   spur_q
);

    assert_enable_sets_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && bus_addr == AW'(A_ENA)) |=>
        ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

    assert_disable_clears_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && bus_addr == AW'(A_DIS)) |=>
        ((en_q & $past(bus_wdata[NSRC-1:0])) == '0));

    assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (en_q[NSRC-1:1] != '0));

    assert_spurious_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_wr && bus_addr == AW'(A_NVEC) && !irq_o) |=>
        (bus_rdata == $past(spur_q)));

    assert_fiq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> en_q[0]);

    assert_fast_idle_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_wr && bus_addr == AW'(A_FVEC) && !fiq_o) |=>
        (bus_rdata == $past(spur_q)));

endmodule

bind irq_vec_ctrl ivc_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .en_q      (en_q),
    .spur_q    (spur_q)
);

// File: tb/sim_irq_vec_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vec_ctrl;

    localparam int NSRC = 8;
    localparam int DW   = 32;
    localparam int AW   = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_i = '0;
    logic            bus_en = 1'b0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   bus_rdata;
    logic            irq_o, fiq_o;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    logic [DW-1:0]   m_vec [NSRC];
    logic [DW-1:0]   m_spur;
    logic [NSRC-1:0] m_en, m_pend;
    logic [DW-1:0]   rd;

    always #2.5 clk = ~clk;

    irq_vec_ctrl #(.NSRC(NSRC), .DW(DW), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rdw(input int a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    function automatic logic exp_irq(input logic [NSRC-1:0] en, input logic [NSRC-1:0] p);
        return |((en & p) >> 1);
    endfunction

    function automatic logic [DW-1:0] exp_vec(input logic [NSRC-1:0] en, input logic [NSRC-1:0] p);
        for (int i = 1; i < NSRC; i++) if (en[i] && p[i]) return m_vec[i];
        return m_spur;
    endfunction

    function automatic int exp_sel(input logic [NSRC-1:0] en, input logic [NSRC-1:0] p);
        for (int i = 1; i < NSRC; i++) if (en[i] && p[i]) return i;
        return -1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d2c3b4a));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", irq_o, 0);
        chk("R1 fiq", fiq_o, 0);
        rdw('h02, rd); chk("R1 mask", rd, 0);
        rdw('h13, rd); chk("R1 mode", rd, 0);

        // R2 / R3 mask commands
        wr('h00, 'h05); rdw('h02, rd); chk("R2 set", rd, 'h05);
        wr('h00, 'h00); rdw('h02, rd); chk("R2 zeros", rd, 'h05);
        wr('h00, 'h80); rdw('h02, rd); chk("R2 add", rd, 'h85);
        wr('h01, 'h04); rdw('h02, rd); chk("R3 clear", rd, 'h81);
        wr('h01, 'h00); rdw('h02, rd); chk("R3 zeros", rd, 'h81);
        wr('h01, 'hFF); rdw('h02, rd); chk("R3 all", rd, 'h00);

        // Program vectors, spurious value, all sources rising edge
        m_spur = $urandom();
        wr('h08, m_spur);
        for (int i = 0; i < NSRC; i++) begin
            m_vec[i] = $urandom();
            wr('h20 + i, m_vec[i]);
            wr('h10 + i, 3);
        end
        rdw('h25, rd); chk("R5 vec readback", rd, m_vec[5]);

        // Random: software-set pending under random masks (R4 R5 R6 R7 R8)
        for (int it = 0; it < 40; it++) begin
            m_en   = NSRC'($urandom());
            m_pend = NSRC'($urandom());
            wr('h00, m_en);
            wr('h01, ~m_en);
            wr('h04, '1);
            wr('h03, m_pend);
            rdw('h02, rd); chk("R2 random mask", rd, m_en);
            chk("R4 irq", irq_o, exp_irq(m_en, m_pend));
            chk("R10 fiq", fiq_o, m_en[0] & m_pend[0]);
            for (int k = 0; k < 2; k++) begin
                int s;
                s = exp_sel(m_en, m_pend);
                rdw('h06, rd);
                chk(s < 0 ? "R7 spurious" : "R5 select", rd, exp_vec(m_en, m_pend));
                if (s > 0) m_pend[s] = 1'b0;
                chk("R6 ack", irq_o, exp_irq(m_en, m_pend));
            end
        end

        // R8 clear on edge source; R4 disabled source does not block
        wr('h01, '1); wr('h04, '1);
        wr('h00, 'h0C); wr('h03, 'h0E);
        wr('h04, 'h04);
        rdw('h06, rd); chk("R8 clear edge", rd, m_vec[3]);
        wr('h03, 'h04); wr('h01, 'h04);
        chk("R4 disabled pending", irq_o, 0);
        wr('h00, 'h04);
        chk("R4 reenabled", irq_o, 1);
        wr('h04, '1);

        // Level high on source 2 (R6 R8 R9)
        wr('h01, '1);
        wr('h12, 1);
        wr('h00, 'h04);
        src_i[2] = 1'b1; settle();
        chk("R9 high level", irq_o, 1);
        rdw('h06, rd); chk("R5 level vec", rd, m_vec[2]);
        chk("R6 level stays", irq_o, 1);
        wr('h04, 'h04); @(negedge clk);
        chk("R8 clear ignored", irq_o, 1);
        src_i[2] = 1'b0; settle();
        chk("R9 high released", irq_o, 0);
        wr('h03, 'h04); settle();
        chk("R8 set ignored", irq_o, 0);
        wr('h12, 0); settle();
        chk("R9 low level", irq_o, 1);
        src_i[2] = 1'b1; settle();
        chk("R9 low released", irq_o, 0);

        // Falling edge on source 3 (R9)
        wr('h01, '1);
        wr('h13, 2);
        wr('h04, '1);
        wr('h00, 'h08);
        src_i[3] = 1'b1; settle();
        chk("R9 fall idle", irq_o, 0);
        src_i[3] = 1'b0; settle();
        chk("R9 fall latch", irq_o, 1);
        repeat (10) @(negedge clk);
        chk("R9 fall hold", irq_o, 1);
        rdw('h06, rd); chk("R9 fall vec", rd, m_vec[3]);
        chk("R6 edge cleared", irq_o, 0);
        rdw('h06, rd); chk("R7 empty read", rd, m_spur);

        // Fast source (R10 R11)
        wr('h01, '1);
        wr('h10, 3);
        wr('h04, '1);
        wr('h00, 'h01);
        src_i[0] = 1'b1; settle();
        chk("R10 fiq rise", fiq_o, 1);
        chk("R10 no irq", irq_o, 0);
        rdw('h07, rd); chk("R11 fast vec", rd, m_vec[0]);
        chk("R11 fast ack", fiq_o, 0);
        rdw('h07, rd); chk("R11 idle read", rd, m_spur);
        rdw('h06, rd); chk("R10 not in normal", rd, m_spur);
        wr('h10, 1); settle();
        chk("R10 fiq high level", fiq_o, 1);
        src_i[0] = 1'b0;
        wr('h10, 0); settle();
        chk("R10 fiq low level", fiq_o, 1);
        chk("R10 irq quiet", irq_o, 0);
        src_i[0] = 1'b1; settle();
        chk("R10 low released", fiq_o, 0);
        wr('h10, 2);
        src_i[0] = 1'b0; settle();
        chk("R10 fiq fall", fiq_o, 1);
        wr('h01, 'h01); @(negedge clk);
        chk("R10 disabled", fiq_o, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule